// File: doc/BRIEF.md
# Microcontroller Watchdog Supervisor with Ignore Window and Mid-Level Disable

This block watches a microcontroller through one digital service line. After the upstream reset logic releases its reset, the block waits through an ignore window, then opens a trigger window. Every qualified falling edge on the service line during that window restarts it. If the trigger window runs out with no qualified edge, the block pulls the shared active-low supervisor output low for a fixed fault pulse. It then starts again with a fresh ignore window. The same output also carries the undervoltage reset, and either source can pull it low.

All time constants are counted in ticks of a shared timebase strobe, `tick_i`. A second digitized input reports that the service line sits at a middle level. When that indication has lasted long enough, it switches supervision off. Removing the indication brings supervision back, starting with an ignore window. Filtering of the mid-level indication, qualification of the service pulse width and the sequencing are all done inside the block. The comparators and the oscillator that makes the ticks are outside it.

Top module: `mcu_wdog_supervisor`

## Requirements
- R1: The supervisor output `sup_n_o` (0 = asserted) is 0 in every cycle where `rel_i` is 0. While synchronous reset is active with `rel_i` at 1, it is 1.
- R2: After `rel_i` rises, the block spends IGN_TICKS ticks in the ignore window and then TRIG_TICKS ticks in the trigger window. With no qualified falling edge, `sup_n_o` goes to 0 exactly IGN_TICKS+TRIG_TICKS ticks after the release edge.
- R3: A fault pulse holds `sup_n_o` at 0 for exactly LOW_TICKS ticks. The ignore window and the trigger window then repeat.
- R4: A qualified falling edge of `svc_i` during the trigger window restarts that window from zero, so periodic service keeps `sup_n_o` at 1 indefinitely.
- R5: A falling edge of `svc_i` is qualified only if `svc_i` was 1 for at least MIN_TICKS ticks before it and then stays 0 for at least MIN_TICKS ticks. A shorter high phase or a shorter low phase is not counted.
- R6: Falling edges of `svc_i` that occur during the ignore window or during a fault pulse have no effect on the timing of the next fault.
- R7: Dropping `rel_i` at any point aborts the sequence. The next release starts again from the ignore window.
- R8: Supervision turns off only after `mid_i` has been 1 for FILT_TICKS consecutive ticks. A run of FILT_TICKS-1 ticks changes nothing.
- R9: When `mid_i` returns to 0, supervision resumes with a full ignore window, one cycle after the filter clears.
- R10: The timers advance only on cycles with `tick_i` at 1. A stall of N cycles in the trigger window delays the fault by N cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timebase strobe; one tick per cycle where it is 1 |
| rel_i | input | 1 | 1 once the upstream reset delay has released; 0 during undervoltage reset |
| svc_i | input | 1 | Digitized service line from the microcontroller |
| mid_i | input | 1 | 1 while the service line is detected at a mid level (disable request) |
| sup_n_o | output | 1 | Shared active-low reset/watchdog output |

## Verification
The bench measures the exact index at which the output falls after a release. A window counter that is off by one tick, or that runs while `tick_i` is low, therefore shows up as a shifted fault. Service pulses with high or low phases one tick short of the minimum must leave the fault where it was; a qualifier that counts one edge too few would accept them and push the fault out. Edges placed inside the ignore window and inside the fault pulse catch a design that arms the trigger logic too early, which would move the next fault. A mid-level run one tick short of the filter length, a long run, and the release of that run catch a filter that triggers early or a resume that skips the ignore window.

// File: rtl/wdog_pkg.sv
// Shared types for the watchdog supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package wdog_pkg;
    typedef enum logic [2:0] {
        WS_IDLE   = 3'd0,
        WS_IGNORE = 3'd1,
        WS_ARMED  = 3'd2,
        WS_FAULT  = 3'd3,
        WS_OFF    = 3'd4
    } wdog_state_e;
endpackage

// File: rtl/wdog_edge_qual.sv
// Service pulse qualifier: emits a one-cycle kick when a falling edge of
// svc_i followed a high phase of at least MIN_TICKS ticks and the low phase
// has since lasted MIN_TICKS ticks. Only edges seen while arm_i is 1 count.
// Assumes: svc_i already synchronous to clk.
module wdog_edge_qual #(
    parameter int MIN_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic arm_i,
    input  logic svc_i,
    output logic kick_o
);
    localparam int CW = $clog2(MIN_TICKS + 1);

    logic          lvl_q;
    logic [CW-1:0] run_q;
    logic          hi_ok_q;
    logic          long_enough;

    assign long_enough = (run_q >= CW'(MIN_TICKS));
    assign kick_o      = arm_i && hi_ok_q && !lvl_q && long_enough;

    // Track the level, its saturating age in ticks, and a valid high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= 1'b0;
            run_q   <= '0;
            hi_ok_q <= 1'b0;
        end else if (svc_i != lvl_q) begin
            lvl_q   <= svc_i;
            run_q   <= tick_i ? CW'(1) : '0;
            hi_ok_q <= arm_i && lvl_q && long_enough;
        end else begin
            if (tick_i && !long_enough) run_q <= run_q + 1'b1;
            if (kick_o || !arm_i) hi_ok_q <= 1'b0;
        end
    end

    // R5: each qualified edge yields a single kick
    p_kick_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |=> !kick_o);
endmodule

// File: rtl/wdog_mid_filter.sv
// Mid-level disable filter: off_o rises after mid_i has been 1 for
// FILT_TICKS consecutive ticks and clears on the first cycle mid_i is 0.
// Assumes: mid_i already synchronous to clk.
module wdog_mid_filter #(
    parameter int FILT_TICKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic mid_i,
    output logic off_o
);
    localparam int CW = $clog2(FILT_TICKS + 1);

    logic [CW-1:0] cnt_q;

    // Count consecutive ticks of the mid-level indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            off_o <= 1'b0;
        end else if (!mid_i) begin
            cnt_q <= '0;
            off_o <= 1'b0;
        end else if (tick_i && !off_o) begin
            if (cnt_q == CW'(FILT_TICKS - 1)) off_o <= 1'b1;
            else                              cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: disable only after a full filter run
    p_off_full_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(off_o) |-> ($past(cnt_q) == CW'(FILT_TICKS - 1) && $past(mid_i)));
    // R9: removal of the indication clears the disable
    p_off_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mid_i |=> !off_o);
endmodule

// File: rtl/wdog_seq_fsm.sv
// Watchdog sequencer: idle until release, then ignore window, trigger
// window restarted by kicks, fault pulse, and back to the ignore window.
// Release loss aborts to idle; the filter's off flag parks it in OFF.
// Assumes: kick_i comes from wdog_edge_qual armed by arm_o.
module wdog_seq_fsm
    import wdog_pkg::*;
#(
    parameter int IGN_TICKS  = 16000,
    parameter int TRIG_TICKS = 96000,
    parameter int LOW_TICKS  = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rel_i,
    input  logic off_i,
    input  logic kick_i,
    output logic arm_o,
    output logic fault_o
);
    localparam int MAXT = (IGN_TICKS > TRIG_TICKS)
                        ? ((IGN_TICKS > LOW_TICKS) ? IGN_TICKS : LOW_TICKS)
                        : ((TRIG_TICKS > LOW_TICKS) ? TRIG_TICKS : LOW_TICKS);
    localparam int CW = $clog2(MAXT + 1);

    wdog_state_e   st_q;
    logic [CW-1:0] cnt_q;

    assign arm_o   = (st_q == WS_ARMED);
    assign fault_o = (st_q == WS_FAULT);

    // Advance the sequence; release loss first, then disable, then timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WS_IDLE;
            cnt_q <= '0;
        end else if (!rel_i) begin
            st_q  <= WS_IDLE;
            cnt_q <= '0;
        end else if (off_i) begin
            st_q  <= WS_OFF;
            cnt_q <= '0;
        end else begin
            case (st_q)
                WS_IGNORE: if (tick_i) begin
                    if (cnt_q == CW'(IGN_TICKS - 1)) begin
                        st_q  <= WS_ARMED;
                        cnt_q <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                WS_ARMED: if (kick_i) begin
                    cnt_q <= '0;
                end else if (tick_i) begin
                    if (cnt_q == CW'(TRIG_TICKS - 1)) begin
                        st_q  <= WS_FAULT;
                        cnt_q <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                WS_FAULT: if (tick_i) begin
                    if (cnt_q == CW'(LOW_TICKS - 1)) begin
                        st_q  <= WS_IGNORE;
                        cnt_q <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                default: begin
                    st_q  <= WS_IGNORE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // R7: release loss returns the sequence to idle
    p_idle_on_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_i |=> (st_q == WS_IDLE));
    // R2: ignore window ends only after its full count on a tick
    p_ignore_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WS_ARMED && $past(st_q) == WS_IGNORE)
            |-> ($past(cnt_q) == CW'(IGN_TICKS - 1) && $past(tick_i)));
    // R2: fault only after a full trigger window without a kick
    p_fault_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WS_FAULT && $past(st_q) == WS_ARMED)
            |-> ($past(cnt_q) == CW'(TRIG_TICKS - 1) && !$past(kick_i)));
    // R3: fault pulse ends after its full count
    p_fault_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WS_IGNORE && $past(st_q) == WS_FAULT)
            |-> ($past(cnt_q) == CW'(LOW_TICKS - 1)));
    // R8: the OFF state is entered only on the filter's request
    p_off_follows_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WS_OFF) |-> $past(off_i));
endmodule

// File: rtl/mcu_wdog_supervisor.sv
// Top of the watchdog supervisor: qualifier, mid-level filter and
// sequencer, with the fault pulse merged into the release signal on one
// active-low output. Assumes all inputs are synchronous to clk.
module mcu_wdog_supervisor #(
    parameter int MIN_TICKS  = 1,
    parameter int FILT_TICKS = 500,
    parameter int IGN_TICKS  = 16000,
    parameter int TRIG_TICKS = 96000,
    parameter int LOW_TICKS  = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rel_i,
    input  logic svc_i,
    input  logic mid_i,
    output logic sup_n_o
);
    logic kick;
    logic arm;
    logic off;
    logic fault;

    wdog_edge_qual #(.MIN_TICKS(MIN_TICKS)) u_qual (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .arm_i(arm), .svc_i(svc_i), .kick_o(kick)
    );

    wdog_mid_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .mid_i(mid_i), .off_o(off)
    );

    wdog_seq_fsm #(
        .IGN_TICKS(IGN_TICKS), .TRIG_TICKS(TRIG_TICKS), .LOW_TICKS(LOW_TICKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rel_i(rel_i),
        .off_i(off), .kick_i(kick), .arm_o(arm), .fault_o(fault)
    );

    // Either the reset source or the fault pulse pulls the output low.
    assign sup_n_o = rel_i && !fault;

    // R1: output low whenever the reset source is active
    p_low_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_i |-> !sup_n_o);
endmodule

// File: tb/test_mcu_wdog_supervisor.sv
`timescale 1ns/1ps
module test_mcu_wdog_supervisor;
    localparam int MINW = 3;
    localparam int FILT = 8;
    localparam int IGN  = 10;
    localparam int TRIG = 30;
    localparam int LOWT = 8;
    localparam int FIRST = IGN + TRIG;

    // Service pulse vectors: high length, low length, expected to count.
    localparam int VEC_N = 6;
    localparam int V_HI [VEC_N] = '{3, 2, 3, 6, 1, 4};
    localparam int V_LO [VEC_N] = '{3, 3, 2, 9, 1, 3};
    localparam int V_OK [VEC_N] = '{1, 0, 0, 1, 0, 1};

    logic clk = 1'b0;
    logic rst_n, tick, rel, svc, mid;
    logic sup_n;

    int checks = 0;
    int errors = 0;
    int idx, first_low, back_high, second_low;

    always #2 clk = ~clk;

    mcu_wdog_supervisor #(
        .MIN_TICKS(MINW), .FILT_TICKS(FILT), .IGN_TICKS(IGN),
        .TRIG_TICKS(TRIG), .LOW_TICKS(LOWT)
    ) i_mcu_wdog_supervisor (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rel_i(rel),
        .svc_i(svc), .mid_i(mid), .sup_n_o(sup_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance to the next falling clock edge and log the output.
    task automatic step();
        @(negedge clk);
        idx++;
        if (!sup_n) begin
            if (first_low < 0) first_low = idx;
            else if (back_high >= 0 && second_low < 0) second_low = idx;
        end else if (first_low >= 0 && back_high < 0) begin
            back_high = idx;
        end
    endtask

    task automatic run_to(input int last);
        while (idx < last) step();
    endtask

    task automatic clear_log();
        idx = -1; first_low = -1; back_high = -1; second_low = -1;
    endtask

    // Drop and re-raise the release, index 0 is the first sample after it.
    task automatic start_seq();
        rel = 1'b0; svc = 1'b0; mid = 1'b0; tick = 1'b1;
        step(); step();
        rel = 1'b1;
        clear_log();
    endtask

    task automatic pulse(input int hi, input int lo);
        svc = 1'b1;
        repeat (hi) step();
        svc = 1'b0;
        repeat (lo) step();
    endtask

    initial begin
        rst_n = 1'b0; rel = 1'b0; tick = 1'b1; svc = 1'b0; mid = 1'b0;
        clear_log();
        repeat (2) @(negedge clk);
        chk(sup_n == 1'b0, "R1 low in reset", int'(sup_n), 0);
        rel = 1'b1;
        @(negedge clk);
        chk(sup_n == 1'b1, "R1 high while idle", int'(sup_n), 1);
        rel = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Vector walk: pulse widths around the minimum inside the trigger window.
        for (int v = 0; v < VEC_N; v++) begin
            start_seq();
            run_to(IGN + 2);
            pulse(V_HI[v], V_LO[v]);
            svc = 1'b1;
            run_to(FIRST + V_HI[v] + V_LO[v] + TRIG + 5);
            if (V_OK[v] != 0)
                chk(first_low > FIRST, "R5 R4 qualified pulse restarts", first_low, FIRST + 1);
            else
                chk(first_low == FIRST, "R5 short phase ignored", first_low, FIRST);
            svc = 1'b0;
        end

        // No service; edges inside the fault pulse.
        start_seq();
        run_to(FIRST);
        chk(first_low == FIRST, "R2 fault time", first_low, FIRST);
        pulse(3, 3);
        run_to(2 * FIRST + LOWT + 2);
        chk(back_high == FIRST + LOWT, "R3 fault length", back_high, FIRST + LOWT);
        chk(second_low == 2 * FIRST + LOWT, "R3 R6 repeat after fault", second_low, 2 * FIRST + LOWT);

        // Edge qualified inside the ignore window.
        start_seq();
        pulse(3, 4);
        run_to(FIRST + 3);
        chk(first_low == FIRST, "R6 ignore window edge", first_low, FIRST);

        // Periodic service.
        start_seq();
        run_to(IGN + 1);
        for (int k = 0; k < 10; k++) begin
            pulse(3, 3);
            repeat (9) step();
        end
        chk(first_low < 0, "R4 periodic service", first_low, -1);

        // Release loss mid-window.
        start_seq();
        run_to(IGN + 5);
        rel = 1'b0;
        step();
        chk(sup_n == 1'b0, "R7 R1 low on loss", int'(sup_n), 0);
        repeat (3) step();
        rel = 1'b1;
        clear_log();
        run_to(FIRST + 2);
        chk(first_low == FIRST, "R7 restart after loss", first_low, FIRST);

        // Mid-level run one tick short.
        start_seq();
        run_to(IGN + 2);
        mid = 1'b1;
        repeat (FILT - 1) step();
        mid = 1'b0;
        run_to(FIRST + 2);
        chk(first_low == FIRST, "R8 short mid run", first_low, FIRST);

        // Long mid-level run, then removal.
        start_seq();
        run_to(IGN + 2);
        mid = 1'b1;
        run_to(3 * (FIRST + LOWT));
        chk(first_low < 0, "R8 disabled", first_low, -1);
        mid = 1'b0;
        clear_log();
        run_to(FIRST + 4);
        chk(first_low == FIRST + 1, "R9 resume with ignore", first_low, FIRST + 1);

        // Tick stall inside the trigger window.
        start_seq();
        run_to(IGN + 5);
        tick = 1'b0;
        repeat (20) step();
        tick = 1'b1;
        run_to(FIRST + 25);
        chk(first_low == FIRST + 20, "R10 stall delays fault", first_low, FIRST + 20);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule